// File: doc/BRIEF.md
# Extended-Physical-Address Page Table Walker

This block turns a 32-bit linear address into a 36-bit physical address by reading a three-level page table from memory. A request carries the linear address, a 27-bit root field that locates the top table, and an enable flag for the extended translation mode. With the flag set, the block reads one 64-bit entry per level over a simple request/response memory port. The walk ends at a 4 KB page after three reads, at a 2 MB large page after two reads, or at the first entry whose present bit is clear. With the flag clear, the block returns the linear address unchanged and reads nothing.

The top table has four entries, and each one covers a quarter of the linear space. The middle and bottom tables have 512 entries each. An entry carries a 24-bit frame number in bits 35:12. That frame locates either the next table or the final page. The remaining bits are flags, and only the present flag and the large-page flag are read. The block handles one request at a time. It drops its ready output for the whole walk and pulses a done strobe together with the result.

Top module: `pae_walker`

## Requirements
- R1: During reset and right after it, `req_ready` is 1, and `done` and `mem_req_valid` are 0.
- R2: A request accepted with `req_ext_en` = 0 gives `done` = 1 in the next cycle, with `done_paddr` equal to `req_lin` zero-extended to 36 bits, `done_fault` = 0, `done_code` = 0, `done_large` = 0, and no memory read.
- R3: A request accepted with `req_ext_en` = 1 issues its first read in the next cycle, at address ({`req_root`, 5'b0} + `req_lin`[31:30]*8), zero-extended to 36 bits. Each read is a single-cycle `mem_req_valid` pulse to an 8-byte-aligned address.
- R4: After a present top entry, the next read goes to ({entry[35:12], 12'b0} + `req_lin`[29:21]*8).
- R5: After a present middle entry whose bit 7 is 0, the next read goes to ({entry[35:12], 12'b0} + `req_lin`[20:12]*8).
- R6: A present bottom entry ends the walk after three reads, with `done_paddr` = {entry[35:12], `req_lin`[11:0]}, `done_large` = 0, `done_fault` = 0 and `done_code` = 0.
- R7: A present middle entry with bit 7 = 1 ends the walk after two reads, with `done_paddr` = {entry[35:21], `req_lin`[20:0]}, `done_large` = 1 and `done_fault` = 0.
- R8: An entry with bit 0 = 0 ends the walk with no further read. The result is `done_fault` = 1, `done_paddr` = 0, `done_large` = 0, and `done_code` = 1, 2 or 3 when the entry came from the top, middle or bottom level.
- R9: `req_ready` is 0 from the cycle after a translating request is accepted until the cycle that shows `done`. Requests offered during that time are ignored and do not change the addresses or the result of the walk in progress.
- R10: Entry bits 63:36 and 11:1 have no effect, except bit 7 of a middle entry. Bit 7 of a top or bottom entry is ignored.
- R11: `done` is registered. It rises in the cycle after the response that ends the walk and stays high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_lin | input | 32 | Linear address to translate |
| req_root | input | 27 | Top-table base in 32-byte units |
| req_ext_en | input | 1 | 1: walk the tables; 0: pass the address through |
| mem_req_valid | output | 1 | Single-cycle read request |
| mem_req_addr | output | 36 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | Result strobe |
| done_fault | output | 1 | Walk ended on a non-present entry |
| done_code | output | 2 | Level of the faulting entry: 1 top, 2 middle, 3 bottom; 0 when there is no fault |
| done_paddr | output | 36 | Translated physical address |
| done_large | output | 1 | Result is a large page |

## Verification
The assertions assume that memory answers each read exactly once, at least one cycle after the request pulse and before the next request. They also assume that `mem_rsp_valid` stays low when no read is outstanding. The bench meets this with a responder that waits for the request pulse, then waits one to four cycles before driving a single-cycle response. It never raises `mem_rsp_valid` otherwise. The bench offers stray requests only while a walk is in progress, and it applies reset in the middle of one walk. It then checks that the block restarts cleanly from idle.

// File: rtl/pae_walker_pkg.sv
`timescale 1ns/1ps
package pae_walker_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } walk_state_e;

   // Level codes double as fault codes on the result port.
   typedef enum logic [1:0] {
      LVL_NONE = 2'd0,
      LVL_TOP  = 2'd1,
      LVL_MID  = 2'd2,
      LVL_BOT  = 2'd3
   } walk_lvl_e;

endpackage

// File: rtl/pae_entry_addr.sv
`timescale 1ns/1ps
module pae_entry_addr #(
   parameter int unsigned PA_W   = 36,
   parameter int unsigned IDX_W  = 9,
   parameter int unsigned ENT_LG = 3,
   parameter bit          CONCAT = 1'b1
) (
   input  logic [PA_W-1:0]  tbl_base,
   input  logic [IDX_W-1:0] idx,
   output logic [PA_W-1:0]  ent_addr
);

   localparam int unsigned LOW_W = IDX_W + ENT_LG;

   generate
      if (LOW_W >= PA_W) begin : g_bad_width
         $error("pae_entry_addr: index field does not fit the address");
      end

      if (CONCAT) begin : g_concat
         // The base is aligned, so the index simply replaces its zero low bits.
         logic unused_base_low;
         assign unused_base_low = ^tbl_base[LOW_W-1:0];
         assign ent_addr = {tbl_base[PA_W-1:LOW_W], idx, {ENT_LG{1'b0}}};
      end else begin : g_adder
         logic [PA_W-1:0] idx_ext;
         assign idx_ext  = {{(PA_W-LOW_W){1'b0}}, idx, {ENT_LG{1'b0}}};
         assign ent_addr = tbl_base + idx_ext;
      end
   endgenerate

endmodule

// File: rtl/pae_walk_ctrl.sv
`timescale 1ns/1ps
module pae_walk_ctrl
   import pae_walker_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_walk,
   input  logic      rsp_valid,
   input  logic      ent_present,
   input  logic      ent_large,
   output logic      req_ready,
   output logic      issue,
   output walk_lvl_e lvl,
   output logic      step,
   output logic      end_fault,
   output logic      end_large,
   output logic      end_small
);

   walk_state_e state_q;
   walk_lvl_e   lvl_q;
   logic        take_rsp;

   always_comb begin
      req_ready = (state_q == ST_IDLE);
      issue     = (state_q == ST_ISSUE);
      take_rsp  = (state_q == ST_WAIT) && rsp_valid;
      end_fault = take_rsp && !ent_present;
      end_large = take_rsp && ent_present && (lvl_q == LVL_MID) && ent_large;
      end_small = take_rsp && ent_present && (lvl_q == LVL_BOT);
      step      = take_rsp && ent_present && !end_large && !end_small;
      lvl       = lvl_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lvl_q   <= LVL_NONE;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_walk) begin
                  state_q <= ST_ISSUE;
                  lvl_q   <= LVL_TOP;
               end
            end
            ST_ISSUE: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (end_fault || end_large || end_small) begin
                  state_q <= ST_IDLE;
                  lvl_q   <= LVL_NONE;
               end else if (step) begin
                  state_q <= ST_ISSUE;
                  lvl_q   <= walk_lvl_e'(lvl_q + 2'd1);
               end
            end
            default: begin
               state_q <= ST_IDLE;
               lvl_q   <= LVL_NONE;
            end
         endcase
      end
   end

endmodule

// File: rtl/pae_walk_result.sv
`timescale 1ns/1ps
module pae_walk_result #(
   parameter int unsigned LIN_W       = 32,
   parameter int unsigned PA_W        = 36,
   parameter int unsigned PG_OFF_W    = 12,
   parameter int unsigned LARGE_OFF_W = 21
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bypass,
   input  logic [LIN_W-1:0]       byp_lin,
   input  logic                   end_fault,
   input  logic                   end_large,
   input  logic                   end_small,
   input  logic [1:0]             fault_lvl,
   input  logic [LARGE_OFF_W-1:0] walk_off,
   input  logic [PA_W-PG_OFF_W-1:0] ent_frame,
   output logic                   done,
   output logic                   done_fault,
   output logic [1:0]             done_code,
   output logic [PA_W-1:0]        done_paddr,
   output logic                   done_large
);

   localparam int unsigned FRAME_W = PA_W - PG_OFF_W;
   localparam int unsigned LFRM_W  = PA_W - LARGE_OFF_W;

   logic [PA_W-1:0] small_pa, large_pa, byp_pa;

   always_comb begin
      small_pa = {ent_frame, walk_off[PG_OFF_W-1:0]};
      large_pa = {ent_frame[FRAME_W-1 -: LFRM_W], walk_off};
      byp_pa   = {{(PA_W-LIN_W){1'b0}}, byp_lin};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done       <= 1'b0;
         done_fault <= 1'b0;
         done_code  <= 2'd0;
         done_paddr <= '0;
         done_large <= 1'b0;
      end else begin
         done <= bypass || end_fault || end_large || end_small;
         if (bypass) begin
            done_fault <= 1'b0;
            done_code  <= 2'd0;
            done_paddr <= byp_pa;
            done_large <= 1'b0;
         end else if (end_fault) begin
            done_fault <= 1'b1;
            done_code  <= fault_lvl;
            done_paddr <= '0;
            done_large <= 1'b0;
         end else if (end_large) begin
            done_fault <= 1'b0;
            done_code  <= 2'd0;
            done_paddr <= large_pa;
            done_large <= 1'b1;
         end else if (end_small) begin
            done_fault <= 1'b0;
            done_code  <= 2'd0;
            done_paddr <= small_pa;
            done_large <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pae_walker.sv
`timescale 1ns/1ps
module pae_walker
   import pae_walker_pkg::*;
#(
   parameter int unsigned LIN_W       = 32,
   parameter int unsigned PA_W        = 36,
   parameter int unsigned ROOT_W      = 27,
   parameter int unsigned ENT_W       = 64,
   parameter int unsigned TOP_IDX_W   = 2,
   parameter int unsigned MID_IDX_W   = 9,
   parameter int unsigned BOT_IDX_W   = 9,
   parameter int unsigned PG_OFF_W    = 12,
   parameter int unsigned PRESENT_BIT = 0,
   parameter int unsigned LARGE_BIT   = 7,
   parameter bit          ADDR_CONCAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [LIN_W-1:0]  req_lin,
   input  logic [ROOT_W-1:0] req_root,
   input  logic              req_ext_en,
   output logic              mem_req_valid,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [ENT_W-1:0]  mem_rsp_data,
   output logic              done,
   output logic              done_fault,
   output logic [1:0]        done_code,
   output logic [PA_W-1:0]   done_paddr,
   output logic              done_large
);

   localparam int unsigned FRAME_W     = PA_W - PG_OFF_W;
   localparam int unsigned ROOT_SHIFT  = LIN_W - ROOT_W;
   localparam int unsigned ENT_LG      = $clog2(ENT_W / 8);
   localparam int unsigned LARGE_OFF_W = PG_OFF_W + BOT_IDX_W;
   localparam int unsigned MID_LSB     = LARGE_OFF_W;
   localparam int unsigned TOP_LSB     = MID_LSB + MID_IDX_W;

   generate
      if (TOP_IDX_W + MID_IDX_W + BOT_IDX_W + PG_OFF_W != LIN_W) begin : g_bad_split
         $error("pae_walker: index fields do not cover the linear address");
      end
      if (PA_W < LIN_W || PA_W > ENT_W) begin : g_bad_pa
         $error("pae_walker: physical width out of range");
      end
      if (ROOT_SHIFT < TOP_IDX_W + ENT_LG) begin : g_bad_root
         $error("pae_walker: top table alignment too small for its index");
      end
      if (PG_OFF_W < MID_IDX_W + ENT_LG || PG_OFF_W < BOT_IDX_W + ENT_LG) begin : g_bad_tbl
         $error("pae_walker: lower table does not fit one page");
      end
      if (PRESENT_BIT >= PG_OFF_W || LARGE_BIT >= PG_OFF_W || PRESENT_BIT == LARGE_BIT) begin : g_bad_flag
         $error("pae_walker: flag positions must be distinct and below the frame");
      end
   endgenerate

   logic [LIN_W-1:0]   lin_q;
   logic [ROOT_W-1:0]  root_q;
   logic [FRAME_W-1:0] frame_q;

   logic               start_walk, start_byp;
   logic               issue, step;
   logic               end_fault, end_large, end_small;
   walk_lvl_e          lvl;

   logic [FRAME_W-1:0] ent_frame;
   logic               ent_present, ent_large;
   logic               unused_rsp;

   logic [PA_W-1:0]    top_base, low_base;
   logic [PA_W-1:0]    top_addr, mid_addr, bot_addr;

   // Request acceptance and entry fields
   always_comb begin
      start_walk  = req_valid && req_ready && req_ext_en;
      start_byp   = req_valid && req_ready && !req_ext_en;
      ent_frame   = mem_rsp_data[PA_W-1:PG_OFF_W];
      ent_present = mem_rsp_data[PRESENT_BIT];
      ent_large   = mem_rsp_data[LARGE_BIT];
      unused_rsp  = ^mem_rsp_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lin_q   <= '0;
         root_q  <= '0;
         frame_q <= '0;
      end else begin
         if (start_walk) begin
            lin_q  <= req_lin;
            root_q <= req_root;
         end
         if (step) begin
            frame_q <= ent_frame;
         end
      end
   end

   pae_walk_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_walk  (start_walk),
      .rsp_valid   (mem_rsp_valid),
      .ent_present (ent_present),
      .ent_large   (ent_large),
      .req_ready   (req_ready),
      .issue       (issue),
      .lvl         (lvl),
      .step        (step),
      .end_fault   (end_fault),
      .end_large   (end_large),
      .end_small   (end_small)
   );

   // Table bases and per-level entry addresses
   always_comb begin
      top_base = {{(PA_W-LIN_W){1'b0}}, root_q, {ROOT_SHIFT{1'b0}}};
      low_base = {frame_q, {PG_OFF_W{1'b0}}};
   end

   pae_entry_addr #(
      .PA_W(PA_W), .IDX_W(TOP_IDX_W), .ENT_LG(ENT_LG), .CONCAT(ADDR_CONCAT)
   ) u_top_addr (
      .tbl_base (top_base),
      .idx      (lin_q[TOP_LSB +: TOP_IDX_W]),
      .ent_addr (top_addr)
   );

   pae_entry_addr #(
      .PA_W(PA_W), .IDX_W(MID_IDX_W), .ENT_LG(ENT_LG), .CONCAT(ADDR_CONCAT)
   ) u_mid_addr (
      .tbl_base (low_base),
      .idx      (lin_q[MID_LSB +: MID_IDX_W]),
      .ent_addr (mid_addr)
   );

   pae_entry_addr #(
      .PA_W(PA_W), .IDX_W(BOT_IDX_W), .ENT_LG(ENT_LG), .CONCAT(ADDR_CONCAT)
   ) u_bot_addr (
      .tbl_base (low_base),
      .idx      (lin_q[PG_OFF_W +: BOT_IDX_W]),
      .ent_addr (bot_addr)
   );

   always_comb begin
      mem_req_valid = issue;
      unique case (lvl)
         LVL_MID: mem_req_addr = mid_addr;
         LVL_BOT: mem_req_addr = bot_addr;
         default: mem_req_addr = top_addr;
      endcase
   end

   pae_walk_result #(
      .LIN_W(LIN_W), .PA_W(PA_W), .PG_OFF_W(PG_OFF_W), .LARGE_OFF_W(LARGE_OFF_W)
   ) u_result (
      .clk        (clk),
      .rst_n      (rst_n),
      .bypass     (start_byp),
      .byp_lin    (req_lin),
      .end_fault  (end_fault),
      .end_large  (end_large),
      .end_small  (end_small),
      .fault_lvl  (lvl),
      .walk_off   (lin_q[LARGE_OFF_W-1:0]),
      .ent_frame  (ent_frame),
      .done       (done),
      .done_fault (done_fault),
      .done_code  (done_code),
      .done_paddr (done_paddr),
      .done_large (done_large)
   );

endmodule

// File: rtl/pae_walker_chk.sv
`timescale 1ns/1ps
module pae_walker_chk #(
   parameter int unsigned LIN_W     = 32,
   parameter int unsigned PA_W      = 36,
   parameter int unsigned ROOT_W    = 27,
   parameter int unsigned ENT_W     = 64,
   parameter int unsigned TOP_IDX_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [LIN_W-1:0]  req_lin,
   input logic [ROOT_W-1:0] req_root,
   input logic              req_ext_en,
   input logic              mem_req_valid,
   input logic [PA_W-1:0]   mem_req_addr,
   input logic              mem_rsp_valid,
   input logic [ENT_W-1:0]  mem_rsp_data,
   input logic              done,
   input logic              done_fault,
   input logic [1:0]        done_code,
   input logic [PA_W-1:0]   done_paddr,
   input logic              done_large
);

   localparam int unsigned ROOT_SHIFT = LIN_W - ROOT_W;

   logic unused_chk;
   assign unused_chk = ^{mem_rsp_valid, mem_rsp_data};

   logic            take_walk, take_byp;
   logic [PA_W-1:0] first_addr;
   assign take_walk  = req_valid && req_ready && req_ext_en;
   assign take_byp   = req_valid && req_ready && !req_ext_en;
   assign first_addr = {{(PA_W-LIN_W){1'b0}}, req_root, {ROOT_SHIFT{1'b0}}}
                     + ({{(PA_W-TOP_IDX_W){1'b0}}, req_lin[LIN_W-1 -: TOP_IDX_W]} << 3);

   assert_bypass_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take_byp |=> done && !done_fault && !done_large && (done_code == 2'd0)
                   && (done_paddr == {{(PA_W-LIN_W){1'b0}}, $past(req_lin)}));

   assert_bypass_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take_byp |=> !mem_req_valid);

   assert_first_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take_walk |=> mem_req_valid && (mem_req_addr == $past(first_addr)));

   assert_read_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);

   assert_read_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

   assert_large_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_large) |-> !done_fault && (done_code == 2'd0));

   assert_fault_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault) |-> (done_code != 2'd0) && (done_paddr == '0) && !done_large);

   assert_ok_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_fault) |-> (done_code == 2'd0));

   assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   assert_walk_drops_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      take_walk |=> !req_ready);

   assert_done_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

endmodule

bind pae_walker pae_walker_chk #(
   .LIN_W(LIN_W), .PA_W(PA_W), .ROOT_W(ROOT_W), .ENT_W(ENT_W), .TOP_IDX_W(TOP_IDX_W)
) u_chk (.*);

// File: tb/pae_walker_bench.sv
`timescale 1ns/1ps
module pae_walker_bench;

   typedef struct packed {
      logic [31:0] lin;
      logic [26:0] root;
      logic        en;
      logic [63:0] e1;
      logic [63:0] e2;
      logic [63:0] e3;
      logic [1:0]  gap;
      logic        junk;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      // bypass (R2)
      '{32'hDEAD_BEEF, 27'h000_0000, 1'b0, 64'h0, 64'h0, 64'h0, 2'd0, 1'b0},
      // small page with flag noise in the bottom entry (R3 R4 R5 R6 R10)
      '{32'h4123_4567, 27'h000_1234, 1'b1, 64'h0000_0000_0012_3001,
        64'h0000_0004_5678_9003, 64'hFFF0_000A_BCDE_FF01, 2'd0, 1'b0},
      // large page (R7)
      '{32'hC03F_FFFF, 27'h2AA_AAAA, 1'b1, 64'h0000_0000_0777_7001,
        64'h0000_000F_FE00_0081, 64'h0, 2'd1, 1'b0},
      // top fault with all other bits set (R8 R10)
      '{32'h8000_1000, 27'h000_0001, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE,
        64'h0, 64'h0, 2'd0, 1'b0},
      // middle fault, large bit set but not present (R8)
      '{32'h1234_5678, 27'h100_0000, 1'b1, 64'h0000_0000_0040_0001,
        64'h0000_0001_2345_6080, 64'h0, 2'd2, 1'b0},
      // bottom fault (R8)
      '{32'hFFFF_FFFF, 27'h7FF_FFFF, 1'b1, 64'h0000_000F_FFFF_F001,
        64'h0000_0008_8888_8001, 64'h0000_000F_FFFF_F0FE, 2'd0, 1'b0},
      // top and bottom bit 7 ignored, stray requests mid-walk (R9 R10)
      '{32'h7FFF_F123, 27'h055_5555, 1'b1, 64'hABC0_0000_0055_5081,
        64'h0000_0003_3333_3001, 64'h1230_0006_6666_6081, 2'd3, 1'b1},
      // bypass all ones (R2)
      '{32'hFFFF_FFFF, 27'h7FF_FFFF, 1'b0, 64'h0, 64'h0, 64'h0, 2'd0, 1'b0},
      // large page, zero address, stray requests (R7 R9)
      '{32'h0000_0000, 27'h7FF_FFFF, 1'b1, 64'h8000_0009_0000_0001,
        64'hFFFF_FFF1_3F3F_FFFF, 64'h0, 2'd2, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_lin = '0;
   logic [26:0] req_root = '0;
   logic        req_ext_en = 1'b0;
   logic        mem_req_valid;
   logic [35:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        done, done_fault, done_large;
   logic [1:0]  done_code;
   logic [35:0] done_paddr;

   int n_checks = 0;
   int n_errors = 0;

   always #2.5 clk = ~clk;

   pae_walker u_pae_walker (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_lin(req_lin), .req_root(req_root), .req_ext_en(req_ext_en),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .done_fault(done_fault), .done_code(done_code),
      .done_paddr(done_paddr), .done_large(done_large)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Expected outcome worked out from the requirements.
   task automatic model(input vec_t v, output int reads, output logic [35:0] a1,
                        output logic [35:0] a2, output logic [35:0] a3,
                        output logic [35:0] pa, output logic flt,
                        output logic [1:0] code, output logic lg);
      a1 = '0; a2 = '0; a3 = '0; pa = '0; flt = 0; code = 0; lg = 0;
      if (!v.en) begin
         reads = 0;
         pa = {4'h0, v.lin};
         return;
      end
      a1 = {4'h0, v.root, 5'b0} + 36'(v.lin[31:30]) * 8;
      reads = 1;
      if (!v.e1[0]) begin flt = 1; code = 2'd1; return; end
      a2 = {v.e1[35:12], 12'h000} + 36'(v.lin[29:21]) * 8;
      reads = 2;
      if (!v.e2[0]) begin flt = 1; code = 2'd2; return; end
      if (v.e2[7]) begin lg = 1; pa = {v.e2[35:21], v.lin[20:0]}; return; end
      a3 = {v.e2[35:12], 12'h000} + 36'(v.lin[20:12]) * 8;
      reads = 3;
      if (!v.e3[0]) begin flt = 1; code = 2'd3; return; end
      pa = {v.e3[35:12], v.lin[11:0]};
   endtask

   task automatic run_vec(input vec_t v, input int k);
      int          exp_reads, nreads;
      logic [35:0] ea1, ea2, ea3, epa;
      logic        eflt, elg, got;
      logic [1:0]  ecode;
      logic [35:0] ga [3];
      logic [35:0] gpa;
      logic        gflt, glg;
      logic [1:0]  gcode;
      string       tag;
      model(v, exp_reads, ea1, ea2, ea3, epa, eflt, ecode, elg);
      ga[0] = '0; ga[1] = '0; ga[2] = '0;
      gpa = '0; gflt = 0; glg = 0; gcode = 0;
      tag = $sformatf("vec%0d", k);
      @(negedge clk);
      check({tag, " R9 ready when idle"}, 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_lin = v.lin; req_root = v.root; req_ext_en = v.en;
      @(negedge clk);
      req_valid = 1'b0;
      nreads = 0; got = 0;
      for (int c = 0; c < 80 && !got; c++) begin
         if (done) begin
            got = 1; req_valid = 1'b0;
            gpa = done_paddr; gflt = done_fault; glg = done_large; gcode = done_code;
         end else if (mem_req_valid) begin
            if (nreads < 3) ga[nreads] = mem_req_addr;
            check({tag, " R9 ready low while walking"}, 64'(req_ready), 64'd0);
            if (v.junk) begin
               req_valid = 1'b1; req_lin = ~v.lin; req_root = ~v.root; req_ext_en = 1'b1;
            end
            @(negedge clk);
            repeat (v.gap) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data = (nreads == 0) ? v.e1 : (nreads == 1) ? v.e2 : v.e3;
            nreads++;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data = 64'h5A5A_5A5A_5A5A_5A5A;
         end else begin
            @(negedge clk);
         end
      end
      req_valid = 1'b0;
      check({tag, " R11 walk completes"}, 64'(got), 64'd1);
      check({tag, " R6 R7 R8 read count"}, 64'(nreads), 64'(exp_reads));
      if (exp_reads >= 1) check({tag, " R3 top entry address"}, 64'(ga[0]), 64'(ea1));
      if (exp_reads >= 2) check({tag, " R4 middle entry address"}, 64'(ga[1]), 64'(ea2));
      if (exp_reads >= 3) check({tag, " R5 bottom entry address"}, 64'(ga[2]), 64'(ea3));
      check({tag, " R8 fault flag"}, 64'(gflt), 64'(eflt));
      check({tag, " R8 fault code"}, 64'(gcode), 64'(ecode));
      check({tag, " R7 large flag"}, 64'(glg), 64'(elg));
      check({tag, " R2 R6 R7 R10 physical address"}, 64'(gpa), 64'(epa));
      @(negedge clk);
      check({tag, " R11 done single cycle"}, 64'(done), 64'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin : main
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 ready in reset", 64'(req_ready), 64'd1);
      check("R1 done low in reset", 64'(done), 64'd0);
      check("R1 no read in reset", 64'(mem_req_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready after reset", 64'(req_ready), 64'd1);
      check("R1 done low after reset", 64'(done), 64'd0);

      for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

      // R2: back-to-back pass-through requests, one per cycle
      @(negedge clk);
      req_valid = 1'b1; req_ext_en = 1'b0; req_lin = 32'h1357_9BDF;
      @(negedge clk);
      req_lin = 32'h0246_8ACE;
      check("R2 first pass-through done", 64'(done), 64'd1);
      check("R2 first pass-through addr", 64'(done_paddr), 64'h0_1357_9BDF);
      @(negedge clk);
      req_valid = 1'b0;
      check("R2 second pass-through done", 64'(done), 64'd1);
      check("R2 second pass-through addr", 64'(done_paddr), 64'h0_0246_8ACE);
      check("R2 pass-through no read", 64'(mem_req_valid), 64'd0);

      // R1: reset in the middle of a walk
      @(negedge clk);
      req_valid = 1'b1; req_ext_en = 1'b1; req_lin = 32'h4000_0000; req_root = 27'h1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R3 read issued after accept", 64'(mem_req_valid), 64'd1);
      check("R3 top address", 64'(mem_req_addr), 64'h0_0000_0028);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 ready after mid-walk reset", 64'(req_ready), 64'd1);
      check("R1 no read after mid-walk reset", 64'(mem_req_valid), 64'd0);
      check("R1 done low after mid-walk reset", 64'(done), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      run_vec(VECS[1], 100);

      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule